// File: doc/BRIEF.md
# Host/Local Mailbox Interrupt Unit

This block is a small register file that lets a host bus master and a local processor signal each other. Each side posts 32-bit words into message registers and sets bits in doorbell registers. Those writes raise pending bits in the status register on the receiving side. Each side has its own interrupt mask. One interrupt line goes to the local processor and one goes to the host. Reading a doorbell or a status register clears it. A status read returns only the enabled pending bits. Four level inputs from external queue logic also feed the status registers.

All accesses use one register port: `acc_en` qualifies the cycle, `acc_wr` selects write or read, and `acc_host` tells which side is issuing the access. Every access completes in the cycle it is presented and never stalls. Read data is registered and appears in the following cycle.

Top module: `mbx_irq_unit`

## Requirements
- R1: After reset, every register is zero, both interrupt outputs are low, and `rd_data` is zero.
- R2: A host write to offset 0x050 or 0x054 stores the word in inbound message 0 or 1 and sets local-side status bit 0 or 1. A local write to these offsets changes nothing.
- R3: A local write to offset 0x058 or 0x05C stores the word in outbound message 0 or 1 and sets host-side status bit 0 or 1. A host write to these offsets changes nothing.
- R4: A host write to the inbound doorbell (0x068) ORs bits 30:0 into it. Bit 31 of such a write is not stored; it sets local-side status bit 4 (machine check). Nonzero bits 30:0 in the write set local-side status bit 3. A local write to the outbound doorbell (0x060) ORs all 32 bits into it, and a nonzero value sets host-side status bit 3. Writes from the other side to either doorbell are ignored.
- R5: Reading a doorbell returns its contents and clears it to zero.
- R6: Reading the local-side status (0x100) or the host-side status (0x030) returns the status ANDed with that side's mask. The read clears every status bit, including the masked ones.
- R7: While `ipq_nonempty`, `ipq_overflow` or `ofq_overflow` is high, local-side status bit 5, 7 or 8 is set at each clock. While `opq_nonempty` is high, host-side status bit 5 is set at each clock.
- R8: When an event sets a status bit in the same cycle as a read of that status register, the bit is set afterwards, and the read returns the value from before that cycle.
- R9: `irq_local` is high exactly when some local-side status bit and its mask bit are both 1. `irq_host` is high under the same condition on the host side.
- R10: The local-side mask (0x104) implements bits 0,1,3,4,5,7,8. The host-side mask (0x034) implements bits 0,1,3,5. Either side can write either mask. Unimplemented mask and status bits read as zero.
- R11: Reads of unmapped offsets return zero, and writes to unmapped offsets change no state.
- R12: Read data appears on `rd_data` in the cycle after the read. `rd_data` is zero in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_host | input | 1 | 1 = host access, 0 = local access |
| acc_addr | input | 12 | Register byte offset |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the read |
| ipq_nonempty | input | 1 | Inbound post queue holds entries |
| ipq_overflow | input | 1 | Inbound post queue overflowed |
| ofq_overflow | input | 1 | Outbound free queue overflowed |
| opq_nonempty | input | 1 | Outbound post queue holds entries |
| irq_local | output | 1 | Interrupt to the local processor |
| irq_host | output | 1 | Interrupt to the host |

## Verification
The hardest case to reach is a status event that lands in the same cycle as the read that clears it. The single access port means a register write can never coincide with a read. The bench therefore holds a queue input high across a status read, then drops it, and reads again. This checks that the bit survives the clearing read and is gone only after a later read. The bench also sets a masked bit, reads the status while the mask hides it, and then re-enables the mask. This shows that the read cleared the bit even though it returned zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_MSG = 2;

  localparam logic [ADDR_W-1:0] OFS_OUT_STAT = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_OUT_MASK = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_IN_MSG   = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_OUT_MSG  = 12'h058;
  localparam logic [ADDR_W-1:0] OFS_OUT_DB   = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_IN_DB    = 12'h068;
  localparam logic [ADDR_W-1:0] OFS_IN_STAT  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_IN_MASK  = 12'h104;

  localparam int unsigned B_DB    = 3;
  localparam int unsigned B_MCHK  = 4;
  localparam int unsigned B_PQNE  = 5;
  localparam int unsigned B_PQOVF = 7;
  localparam int unsigned B_FQOVF = 8;
  localparam int unsigned B_MCREQ = 31;

  localparam logic [DATA_W-1:0] IN_VALID  = 32'h0000_01BB;
  localparam logic [DATA_W-1:0] OUT_VALID = 32'h0000_002B;
  localparam logic [DATA_W-1:0] IN_DB_KEEP  = 32'h7FFF_FFFF;
  localparam logic [DATA_W-1:0] OUT_DB_KEEP = 32'hFFFF_FFFF;
endpackage

// File: rtl/mbx_stat_unit.sv
module mbx_stat_unit #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] stat_masked,
  output logic [W-1:0] mask_q,
  output logic         irq
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~{W{clr}}) | (set & VALID);
      if (mask_we) mask_q <= mask_wdata & VALID;
    end
  end

  assign stat_masked = stat_q & mask_q;
  assign irq = |stat_masked;

  // R6: a read with no concurrent event empties the register
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ((set & VALID) == '0)) |=> (stat_q == '0));
  // R8: an event in any cycle is present afterwards, even under a clear
  p_new_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((set & VALID) != '0) |=> ((stat_q & $past(set & VALID)) == $past(set & VALID)));
  // R6: without a read, pending bits never drop
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else if (rd) val <= '0;
    else if (wr) val <= val | (wdata & KEEP);
  end

  // R5: a read leaves the doorbell empty
  p_db_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (val == '0));
  // R4: a write only adds bits
  p_db_accum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd) |=> ((val & $past(val)) == $past(val)));
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
  import mbx_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic          acc_host,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  input  logic          ipq_nonempty,
  input  logic          ipq_overflow,
  input  logic          ofq_overflow,
  input  logic          opq_nonempty,
  output logic          irq_local,
  output logic          irq_host
);
  localparam int unsigned OFS_STEP = DW / 8;

  logic do_wr, do_rd, host_wr, local_wr;
  assign do_wr    = acc_en & acc_wr;
  assign do_rd    = acc_en & ~acc_wr;
  assign host_wr  = do_wr & acc_host;
  assign local_wr = do_wr & ~acc_host;

  logic [DW-1:0] in_msg_q  [NUM_MSG];
  logic [DW-1:0] out_msg_q [NUM_MSG];
  logic [NUM_MSG-1:0] in_msg_hit, out_msg_hit;

  for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg
    assign in_msg_hit[g]  = (acc_addr == AW'(OFS_IN_MSG  + g * OFS_STEP));
    assign out_msg_hit[g] = (acc_addr == AW'(OFS_OUT_MSG + g * OFS_STEP));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_msg_q[g]  <= '0;
        out_msg_q[g] <= '0;
      end else begin
        if (host_wr  && in_msg_hit[g])  in_msg_q[g]  <= acc_wdata;
        if (local_wr && out_msg_hit[g]) out_msg_q[g] <= acc_wdata;
      end
    end
  end

  // doorbells
  logic in_db_wr, out_db_wr, in_db_rd, out_db_rd;
  logic [DW-1:0] in_db, out_db;
  assign in_db_wr  = host_wr  && (acc_addr == OFS_IN_DB);
  assign out_db_wr = local_wr && (acc_addr == OFS_OUT_DB);
  assign in_db_rd  = do_rd && (acc_addr == OFS_IN_DB);
  assign out_db_rd = do_rd && (acc_addr == OFS_OUT_DB);

  mbx_doorbell #(.W(DW), .KEEP(IN_DB_KEEP)) u_in_db (
    .clk(clk), .rst_n(rst_n), .wr(in_db_wr), .wdata(acc_wdata),
    .rd(in_db_rd), .val(in_db));
  mbx_doorbell #(.W(DW), .KEEP(OUT_DB_KEEP)) u_out_db (
    .clk(clk), .rst_n(rst_n), .wr(out_db_wr), .wdata(acc_wdata),
    .rd(out_db_rd), .val(out_db));

  // status event vectors
  logic [DW-1:0] in_set, out_set;
  always_comb begin
    in_set = '0;
    for (int i = 0; i < NUM_MSG; i++) begin
      in_set[i]  = host_wr  & in_msg_hit[i];
      out_set[i] = local_wr & out_msg_hit[i];
    end
    in_set[B_DB]    = in_db_wr & (|(acc_wdata & IN_DB_KEEP));
    in_set[B_MCHK]  = in_db_wr & acc_wdata[B_MCREQ];
    in_set[B_PQNE]  = ipq_nonempty;
    in_set[B_PQOVF] = ipq_overflow;
    in_set[B_FQOVF] = ofq_overflow;
    out_set[B_DB]   = out_db_wr & (|acc_wdata);
    out_set[B_PQNE] = opq_nonempty;
  end

  logic [DW-1:0] in_stat_m, out_stat_m, in_mask, out_mask;

  mbx_stat_unit #(.W(DW), .VALID(IN_VALID)) u_in_stat (
    .clk(clk), .rst_n(rst_n), .set(in_set),
    .clr(do_rd && (acc_addr == OFS_IN_STAT)),
    .mask_we(do_wr && (acc_addr == OFS_IN_MASK)), .mask_wdata(acc_wdata),
    .stat_masked(in_stat_m), .mask_q(in_mask), .irq(irq_local));
  mbx_stat_unit #(.W(DW), .VALID(OUT_VALID)) u_out_stat (
    .clk(clk), .rst_n(rst_n), .set(out_set),
    .clr(do_rd && (acc_addr == OFS_OUT_STAT)),
    .mask_we(do_wr && (acc_addr == OFS_OUT_MASK)), .mask_wdata(acc_wdata),
    .stat_masked(out_stat_m), .mask_q(out_mask), .irq(irq_host));

  // read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_MSG; i++) begin
      if (in_msg_hit[i])  rd_mux = in_msg_q[i];
      if (out_msg_hit[i]) rd_mux = out_msg_q[i];
    end
    case (acc_addr)
      OFS_IN_DB:    rd_mux = in_db;
      OFS_OUT_DB:   rd_mux = out_db;
      OFS_IN_STAT:  rd_mux = in_stat_m;
      OFS_OUT_STAT: rd_mux = out_stat_m;
      OFS_IN_MASK:  rd_mux = in_mask;
      OFS_OUT_MASK: rd_mux = out_mask;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= do_rd ? rd_mux : '0;
  end

  // R12: no read, no data
  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> (rd_data == '0));
  // R2: inbound message 0 changes only on a host write to it
  p_inmsg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && in_msg_hit[0]) |=> $stable(in_msg_q[0]));
  // R3: outbound message 0 changes only on a local write to it
  p_outmsg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(local_wr && out_msg_hit[0]) |=> $stable(out_msg_q[0]));
endmodule

// File: tb/test_mbx_irq_unit.sv
module test_mbx_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_host = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic ipq_nonempty = 1'b0, ipq_overflow = 1'b0, ofq_overflow = 1'b0, opq_nonempty = 1'b0;
  logic irq_local, irq_host;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbx_irq_unit i_mbx_irq_unit (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_host(acc_host),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .ipq_nonempty(ipq_nonempty), .ipq_overflow(ipq_overflow),
    .ofq_overflow(ofq_overflow), .opq_nonempty(opq_nonempty),
    .irq_local(irq_local), .irq_host(irq_host));

  // behavioural reference model
  logic [31:0] m_imsg [2], m_omsg [2];
  logic [31:0] m_idb, m_odb, m_ist, m_ost, m_imask, m_omask, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_imsg[0] = 0; m_imsg[1] = 0; m_omsg[0] = 0; m_omsg[1] = 0;
      m_idb = 0; m_odb = 0; m_ist = 0; m_ost = 0; m_imask = 0; m_omask = 0; m_rd = 0;
    end else begin
      logic [31:0] iset, oset;
      iset = 0; oset = 0; m_rd = 0;
      if (acc_en && !acc_wr) begin
        case (acc_addr)
          12'h050: m_rd = m_imsg[0];
          12'h054: m_rd = m_imsg[1];
          12'h058: m_rd = m_omsg[0];
          12'h05C: m_rd = m_omsg[1];
          12'h060: begin m_rd = m_odb; m_odb = 0; end
          12'h068: begin m_rd = m_idb; m_idb = 0; end
          12'h030: begin m_rd = m_ost & m_omask; m_ost = 0; end
          12'h100: begin m_rd = m_ist & m_imask; m_ist = 0; end
          12'h034: m_rd = m_omask;
          12'h104: m_rd = m_imask;
          default: m_rd = 0;
        endcase
      end else if (acc_en) begin
        if (acc_addr == 12'h034) m_omask = acc_wdata & 32'h2B;
        if (acc_addr == 12'h104) m_imask = acc_wdata & 32'h1BB;
        if (acc_host) begin
          if (acc_addr == 12'h050) begin m_imsg[0] = acc_wdata; iset[0] = 1; end
          if (acc_addr == 12'h054) begin m_imsg[1] = acc_wdata; iset[1] = 1; end
          if (acc_addr == 12'h068) begin
            m_idb = m_idb | {1'b0, acc_wdata[30:0]};
            if (acc_wdata[30:0] != 0) iset[3] = 1;
            if (acc_wdata[31]) iset[4] = 1;
          end
        end else begin
          if (acc_addr == 12'h058) begin m_omsg[0] = acc_wdata; oset[0] = 1; end
          if (acc_addr == 12'h05C) begin m_omsg[1] = acc_wdata; oset[1] = 1; end
          if (acc_addr == 12'h060) begin
            m_odb = m_odb | acc_wdata;
            if (acc_wdata != 0) oset[3] = 1;
          end
        end
      end
      if (ipq_nonempty) iset[5] = 1;
      if (ipq_overflow) iset[7] = 1;
      if (ofq_overflow) iset[8] = 1;
      if (opq_nonempty) oset[5] = 1;
      m_ist = m_ist | iset;
      m_ost = m_ost | oset;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rd_data == m_rd, "R12 rd_data vs model", rd_data, m_rd);
      chk(irq_local == |(m_ist & m_imask), "R9 irq_local vs model", {31'b0, irq_local}, {31'b0, |(m_ist & m_imask)});
      chk(irq_host == |(m_ost & m_omask), "R9 irq_host vs model", {31'b0, irq_host}, {31'b0, |(m_ost & m_omask)});
    end
  end

  task automatic wr(input bit host, input logic [11:0] a, input logic [31:0] d);
    acc_en = 1; acc_wr = 1; acc_host = host; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input bit host, input logic [11:0] a, input logic [31:0] exp, input string tag);
    acc_en = 1; acc_wr = 0; acc_host = host; acc_addr = a;
    @(negedge clk);
    acc_en = 0;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rd_data == 0, "R1 rd_data after reset", rd_data, 0);
    chk(!irq_local && !irq_host, "R1 irqs after reset", {30'b0, irq_local, irq_host}, 0);
    rd(1, 12'h100, 32'h0, "R1 local status zero after reset");

    // R10 masks
    wr(0, 12'h104, 32'hFFFF_FFFF);
    rd(1, 12'h104, 32'h0000_01BB, "R10 local mask bits");
    wr(1, 12'h034, 32'hFFFF_FFFF);
    rd(0, 12'h034, 32'h0000_002B, "R10 host mask bits");

    // R2 inbound messages
    wr(1, 12'h050, 32'h1234_5678);
    chk(irq_local == 1, "R9 irq_local on inbound msg", {31'b0, irq_local}, 1);
    rd(0, 12'h050, 32'h1234_5678, "R2 inbound msg0 stored");
    wr(0, 12'h054, 32'h0000_DEAD);
    rd(1, 12'h054, 32'h0, "R2 local write to inbound msg ignored");
    rd(0, 12'h100, 32'h1, "R6 local status msg0");
    rd(0, 12'h100, 32'h0, "R6 status cleared by read");

    // R3 outbound messages
    wr(0, 12'h05C, 32'h0000_CAFE);
    chk(irq_host == 1, "R9 irq_host on outbound msg", {31'b0, irq_host}, 1);
    rd(1, 12'h05C, 32'h0000_CAFE, "R3 outbound msg1 stored");
    wr(1, 12'h058, 32'h5);
    rd(1, 12'h058, 32'h0, "R3 host write to outbound msg ignored");
    rd(1, 12'h030, 32'h2, "R3 host status msg1");

    // R4/R5 doorbells
    wr(1, 12'h068, 32'h3);
    wr(1, 12'h068, 32'h4);
    rd(0, 12'h100, 32'h8, "R4 inbound doorbell status");
    rd(0, 12'h068, 32'h7, "R4 inbound doorbell accumulates");
    rd(0, 12'h068, 32'h0, "R5 inbound doorbell cleared");
    wr(1, 12'h068, 32'h8000_0000);
    rd(0, 12'h100, 32'h10, "R4 machine-check status");
    rd(0, 12'h068, 32'h0, "R4 machine-check bit not stored");
    wr(1, 12'h060, 32'h1);
    rd(1, 12'h030, 32'h0, "R4 host write to outbound doorbell ignored");
    wr(0, 12'h060, 32'h8000_0001);
    rd(1, 12'h030, 32'h8, "R4 outbound doorbell status");
    rd(1, 12'h060, 32'h8000_0001, "R5 outbound doorbell contents");
    rd(1, 12'h060, 32'h0, "R5 outbound doorbell cleared");

    // R6/R9 mask gating, clear regardless of mask
    wr(0, 12'h104, 32'h1);
    wr(1, 12'h068, 32'h1);
    chk(irq_local == 0, "R9 masked doorbell keeps irq low", {31'b0, irq_local}, 0);
    rd(0, 12'h100, 32'h0, "R6 masked status reads zero");
    wr(0, 12'h104, 32'h1BB);
    rd(0, 12'h100, 32'h0, "R6 masked bit was cleared by read");
    rd(0, 12'h068, 32'h1, "R5 doorbell drained");

    // R7/R8 queue inputs and same-cycle set/clear
    ipq_nonempty = 1;
    @(negedge clk);
    chk(irq_local == 1, "R7 queue nonempty raises irq", {31'b0, irq_local}, 1);
    rd(0, 12'h100, 32'h20, "R7 inbound queue nonempty");
    rd(0, 12'h100, 32'h20, "R8 bit kept across clearing read");
    ipq_nonempty = 0;
    rd(0, 12'h100, 32'h20, "R8 set in read cycle kept");
    rd(0, 12'h100, 32'h0, "R6 cleared once input low");
    ofq_overflow = 1; ipq_overflow = 1;
    @(negedge clk);
    ofq_overflow = 0; ipq_overflow = 0;
    rd(0, 12'h100, 32'h180, "R7 overflow bits");
    opq_nonempty = 1;
    @(negedge clk);
    opq_nonempty = 0;
    rd(1, 12'h030, 32'h20, "R7 outbound queue nonempty");

    // R11 unmapped
    wr(1, 12'h200, 32'hFFFF_FFFF);
    wr(0, 12'h03C, 32'hFFFF_FFFF);
    rd(1, 12'h200, 32'h0, "R11 unmapped read");
    rd(0, 12'h100, 32'h0, "R11 unmapped write left status");
    chk(!irq_local && !irq_host, "R11 no irq after unmapped writes", {30'b0, irq_local, irq_host}, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule